// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block owns a small on-chip table of transmit descriptors and walks it as a ring. Each descriptor takes two 32-bit words. The first is a control word that holds the frame length, an ownership (ready) flag, option flags and a completion status field. The second is a pointer to the frame buffer. A host writes and reads the table through a plain word port.

The walker watches the descriptor at its current index. When that descriptor's ready flag is set, it hands the buffer pointer, the length and the per-frame options to a frame transmitter. It then waits for the transmitter's done pulse and writes the returned status into the control word. Writing the status also clears the ready flag, which returns the descriptor to software.

After the writeback the walker can pulse an interrupt. It then moves to the next descriptor, or back to descriptor 0. The ring therefore ends wherever software sets the wrap flag, or at the last slot of the table.

Top module: `txbd_walker`

## Requirements
- R1: Descriptor d keeps its control word at byte address 8*d and its buffer pointer at 8*d+4. `host_rdata` shows the addressed word combinationally. After reset the walker services descriptors in ring order, starting at descriptor 0.
- R2: When the current control word has bit 15 (ready) set, `tx_start` pulses high for exactly one cycle on the next cycle. On that cycle `tx_ptr` gives the pointer word, `tx_len` gives bits 31:16, `tx_pad` gives bit 12 and `tx_crc` gives bit 11. These outputs and `tx_busy` stay stable until `tx_done`.
- R3: A `tx_done` while busy changes the control word from the next cycle on. Bits 8:0 take `tx_status`, bit 15 is cleared, and every other bit keeps its value.
- R4: While the current descriptor's bit 15 is clear, the walker stays on that index and starts nothing, even when a later descriptor is ready.
- R5: `irq` goes high the cycle after the `tx_done` that completes a descriptor, and only when bit 14 of that descriptor is set.
- R6: `irq` is never high for two consecutive cycles.
- R7: After a descriptor with bit 13 (wrap) set, the next descriptor serviced is descriptor 0. Otherwise the walker moves to the next index, and it returns to 0 after the last slot (NUM_DESC-1).
- R8: Reset clears the whole table and drives `tx_start`, `tx_busy` and `irq` low.
- R9: A host write to a different word, in the same cycle as a status writeback, lands together with the writeback.
- R10: A host write to the control word being written back, in that same cycle, is discarded; the writeback value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | $clog2(NUM_DESC)+3 | Host byte address (word aligned) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Word at host_addr |
| tx_start | output | 1 | One-cycle frame launch pulse |
| tx_busy | output | 1 | A frame is outstanding |
| tx_ptr | output | 32 | Buffer pointer of the frame |
| tx_len | output | 16 | Frame length in bytes |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Frame completion pulse |
| tx_status | input | 9 | Completion status |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A status writeback and a host write can fall on the same clock edge. The bench provokes this by raising `host_wr` on the same negative edge that raises `tx_done`. In one case the host targets the pointer word of the next descriptor. There both values must read back afterwards. In the other case the host targets the control word being retired. There the readback must equal the merged completion word and not the host data.

// File: rtl/txbd_pkg.sv
package txbd_pkg;

  localparam int RDY_BIT  = 15;
  localparam int IRQ_BIT  = 14;
  localparam int WRAP_BIT = 13;
  localparam int PAD_BIT  = 12;
  localparam int CRC_BIT  = 11;
  localparam int ST_W     = 9;

  typedef enum logic {WALK_POLL, WALK_WAIT} walk_state_e;

  typedef struct packed {
    logic [31:0] ptr;
    logic [15:0] len;
    logic        irq;
    logic        wrap;
    logic        pad;
    logic        crc;
  } frame_req_t;

  // Pull the launch fields out of a descriptor pair.
  function automatic frame_req_t decode_desc(logic [31:0] ctl, logic [31:0] ptr);
    frame_req_t r;
    r.ptr  = ptr;
    r.len  = ctl[31:16];
    r.irq  = ctl[IRQ_BIT];
    r.wrap = ctl[WRAP_BIT];
    r.pad  = ctl[PAD_BIT];
    r.crc  = ctl[CRC_BIT];
    return r;
  endfunction

  // Completion merge: status into low field, ownership back to software.
  function automatic logic [31:0] retire_word(logic [31:0] ctl, logic [ST_W-1:0] st);
    logic [31:0] r;
    r = ctl;
    r[RDY_BIT] = 1'b0;
    r[ST_W-1:0] = st;
    return r;
  endfunction

endpackage

// File: rtl/txbd_store.sv
module txbd_store #(
  parameter int NUM_DESC = 4,
  parameter int IDX_W    = 2,
  parameter int WORD_AW  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [WORD_AW-1:0] host_word,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               wb_we,
  input  logic [WORD_AW-1:0] wb_word,
  input  logic [31:0]        wb_data,
  input  logic [IDX_W-1:0]   desc_idx,
  output logic [31:0]        cur_ctl,
  output logic [31:0]        cur_ptr
);
  import txbd_pkg::*;

  localparam int WORDS = 2 * NUM_DESC;

  logic [31:0] words_q [WORDS];

  // Named event: host and walker aim at the same word this cycle.
  logic same_word_clash;
  assign same_word_clash = wb_we && host_we && (host_word == wb_word);

  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      if (!rst_n)
        words_q[w] <= '0;
      else if (wb_we && wb_word == WORD_AW'(w))
        words_q[w] <= wb_data;
      else if (host_we && host_word == WORD_AW'(w))
        words_q[w] <= host_wdata;
    end
  end

  assign host_rdata = words_q[host_word];
  assign cur_ctl    = words_q[{desc_idx, 1'b0}];
  assign cur_ptr    = words_q[{desc_idx, 1'b1}];

  a_r3_ready_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |=> !words_q[$past(wb_word)][RDY_BIT]);

  a_r10_walker_wins: assert property (@(posedge clk) disable iff (!rst_n)
    same_word_clash |=> (words_q[$past(wb_word)] == $past(wb_data)));

  a_r9_host_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !same_word_clash) |=> (words_q[$past(host_word)] == $past(host_wdata)));

endmodule

// File: rtl/txbd_seq.sv
module txbd_seq #(
  parameter int NUM_DESC = 4,
  parameter int IDX_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [31:0]               cur_ctl,
  input  logic [31:0]               cur_ptr,
  input  logic                      tx_done,
  input  logic [txbd_pkg::ST_W-1:0] tx_status,
  output logic [IDX_W-1:0]          desc_idx,
  output logic                      wb_we,
  output logic [31:0]               wb_data,
  output logic                      tx_start,
  output logic                      tx_busy,
  output txbd_pkg::frame_req_t      req,
  output logic                      irq
);
  import txbd_pkg::*;

  walk_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  frame_req_t       req_q;
  logic             start_q;
  logic             irq_q;

  // Named internal events.
  logic launch;
  logic retire;
  assign launch = (state_q == WALK_POLL) && cur_ctl[RDY_BIT];
  assign retire = (state_q == WALK_WAIT) && tx_done;

  function automatic logic [IDX_W-1:0] step_idx(logic [IDX_W-1:0] i, logic wrap);
    if (wrap || i == IDX_W'(NUM_DESC - 1))
      return '0;
    return i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WALK_POLL;
      idx_q   <= '0;
      req_q   <= '0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      start_q <= launch;
      irq_q   <= retire && req_q.irq;
      if (launch) begin
        req_q   <= decode_desc(cur_ctl, cur_ptr);
        state_q <= WALK_WAIT;
      end else if (retire) begin
        state_q <= WALK_POLL;
        idx_q   <= step_idx(idx_q, req_q.wrap);
      end
    end
  end

  assign desc_idx = idx_q;
  assign wb_we    = retire;
  assign wb_data  = retire_word(cur_ctl, tx_status);
  assign tx_start = start_q;
  assign tx_busy  = (state_q == WALK_WAIT);
  assign req      = req_q;
  assign irq      = irq_q;

  a_r4_hold_index: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WALK_POLL && !cur_ctl[RDY_BIT]) |=> (idx_q == $past(idx_q)));

  a_r2_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_done) |=> ($stable(req_q) && tx_busy));

  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(retire) && $past(req_q.irq)));

  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && req_q.wrap) |=> (idx_q == '0));

endmodule

// File: rtl/txbd_walker.sv
module txbd_walker #(
  parameter int NUM_DESC = 4,
  localparam int IDX_W   = $clog2(NUM_DESC),
  localparam int WORD_AW = IDX_W + 1,
  localparam int BYTE_AW = WORD_AW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [BYTE_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               tx_start,
  output logic               tx_busy,
  output logic [31:0]        tx_ptr,
  output logic [15:0]        tx_len,
  output logic               tx_pad,
  output logic               tx_crc,
  input  logic               tx_done,
  input  logic [8:0]         tx_status,
  output logic               irq
);
  import txbd_pkg::*;

  logic [WORD_AW-1:0] host_word;
  logic               unused_lsb;
  assign host_word  = host_addr[BYTE_AW-1:2];
  assign unused_lsb = ^host_addr[1:0];

  logic [IDX_W-1:0] desc_idx;
  logic [31:0]      cur_ctl, cur_ptr, wb_data;
  logic             wb_we;
  frame_req_t       req;

  txbd_store #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .WORD_AW(WORD_AW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_wr), .host_word(host_word), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .wb_we(wb_we), .wb_word({desc_idx, 1'b0}), .wb_data(wb_data),
    .desc_idx(desc_idx), .cur_ctl(cur_ctl), .cur_ptr(cur_ptr)
  );

  txbd_seq #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cur_ctl(cur_ctl), .cur_ptr(cur_ptr),
    .tx_done(tx_done), .tx_status(tx_status),
    .desc_idx(desc_idx), .wb_we(wb_we), .wb_data(wb_data),
    .tx_start(tx_start), .tx_busy(tx_busy), .req(req), .irq(irq)
  );

  assign tx_ptr = req.ptr;
  assign tx_len = req.len;
  assign tx_pad = req.pad;
  assign tx_crc = req.crc;

  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !tx_start);

endmodule

// File: tb/txbd_walker_tb_top.sv
module txbd_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_DESC   = 4;
  localparam int AW         = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          tx_start, tx_busy, tx_pad, tx_crc, irq;
  logic [31:0]   tx_ptr;
  logic [15:0]   tx_len;
  logic          tx_done = 1'b0;
  logic [8:0]    tx_status = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  txbd_walker #(.NUM_DESC(NUM_DESC)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_start(tx_start),
    .tx_busy(tx_busy), .tx_ptr(tx_ptr), .tx_len(tx_len), .tx_pad(tx_pad),
    .tx_crc(tx_crc), .tx_done(tx_done), .tx_status(tx_status), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // {len[15:0], irq, wrap, pad, crc, ptr[31:0], status[8:0]}
  localparam logic [60:0] VEC [6] = '{
    {16'd64,     4'b1001, 32'h0000_1000, 9'h000},
    {16'h003C,   4'b0111, 32'h0000_1600, 9'h1A5},
    {16'd1518,   4'b1010, 32'h0000_2C00, 9'h100},
    {16'd1,      4'b0000, 32'h0000_3200, 9'h0FF},
    {16'hFFFF,   4'b1000, 32'hFFFF_FFFC, 9'h001},
    {16'd100,    4'b0010, 32'h0000_3E00, 9'h1FF}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      summary();
      $finish;
    end
  end

  task automatic host_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(logic [AW-1:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  function automatic logic [31:0] ctl_word(logic [15:0] len, logic i, logic w, logic p, logic c);
    return {len, 1'b1, i, w, p, c, 2'b10, 9'h055};
  endfunction

  function automatic logic [31:0] merged(logic [31:0] ctl, logic [8:0] st);
    return (ctl & 32'hFFFF_7E00) | {23'd0, st};
  endfunction

  task automatic arm(int idx, logic [31:0] ptr, logic [31:0] ctl);
    host_write(AW'(idx * 8 + 4), ptr);
    host_write(AW'(idx * 8), ctl);
  endtask

  task automatic wait_start(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (tx_start) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  // Complete the outstanding frame; optional host write on the same edge.
  task automatic finish(int idx, logic [8:0] st, logic [31:0] ctl, logic exp_irq,
                        bit side, logic [AW-1:0] side_a, logic [31:0] side_d);
    logic [31:0] rd;
    @(negedge clk);
    chk("R2 start is one cycle", {31'd0, tx_start}, 32'd0);
    chk("R2 busy held", {31'd0, tx_busy}, 32'd1);
    @(negedge clk);
    tx_done = 1'b1; tx_status = st;
    if (side) begin
      host_wr = 1'b1; host_addr = side_a; host_wdata = side_d;
    end
    @(negedge clk);
    tx_done = 1'b0; host_wr = 1'b0;
    chk("R5 irq after done", {31'd0, irq}, {31'd0, exp_irq});
    host_read(AW'(idx * 8), rd);
    chk("R3 writeback word", rd, merged(ctl, st));
    @(negedge clk);
    chk("R6 irq single cycle", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    int exp_idx;
    bit seen;
    logic [31:0] rd, ctl;
    logic [15:0] len;
    logic [3:0] fl;
    logic [31:0] ptr;
    logic [8:0] st;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 tx_start low", {31'd0, tx_start}, 32'd0);
    chk("R8 tx_busy low", {31'd0, tx_busy}, 32'd0);
    chk("R8 irq low", {31'd0, irq}, 32'd0);
    host_read(5'd0, rd);
    chk("R8 table cleared", rd, 32'd0);
    host_read(5'd28, rd);
    chk("R8 table cleared top", rd, 32'd0);

    exp_idx = 0;
    for (int v = 0; v < 6; v++) begin
      {len, fl, ptr, st} = VEC[v];
      ctl = ctl_word(len, fl[3], fl[2], fl[1], fl[0]);
      arm(exp_idx, ptr, ctl);
      wait_start(seen);
      chk("R1 R7 descriptor started", {31'd0, seen}, 32'd1);
      chk("R2 tx_ptr", tx_ptr, ptr);
      chk("R2 tx_len", {16'd0, tx_len}, {16'd0, len});
      chk("R2 pad/crc", {30'd0, tx_pad, tx_crc}, {30'd0, fl[1], fl[0]});
      finish(exp_idx, st, ctl, fl[3], 1'b0, '0, '0);
      exp_idx = (fl[2] || exp_idx == NUM_DESC - 1) ? 0 : exp_idx + 1;
    end

    // R4: later descriptor ready, current not ready -> no launch
    ctl = ctl_word(16'd80, 1'b0, 1'b0, 1'b0, 1'b1);
    arm(1, 32'h0000_5000, ctl);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_start) seen = 1'b1;
    end
    chk("R4 no skip ahead", {31'd0, seen}, 32'd0);
    chk("R4 still idle", {31'd0, tx_busy}, 32'd0);
    arm(0, 32'h0000_4000, ctl_word(16'd90, 1'b1, 1'b0, 1'b1, 1'b0));
    wait_start(seen);
    chk("R4 current served first", tx_ptr, 32'h0000_4000);
    finish(0, 9'h011, ctl_word(16'd90, 1'b1, 1'b0, 1'b1, 1'b0), 1'b1, 1'b0, '0, '0);
    wait_start(seen);
    chk("R4 next served after", tx_ptr, 32'h0000_5000);
    finish(1, 9'h022, ctl, 1'b0, 1'b0, '0, '0);

    // R9: host writes another word on the writeback edge
    ctl = ctl_word(16'd70, 1'b0, 1'b0, 1'b0, 1'b0);
    arm(2, 32'h0000_6000, ctl);
    wait_start(seen);
    chk("R9 desc2 started", tx_ptr, 32'h0000_6000);
    finish(2, 9'h0AA, ctl, 1'b0, 1'b1, 5'd28, 32'h0000_7000);
    host_read(5'd28, rd);
    chk("R9 host word landed", rd, 32'h0000_7000);

    // R10: host writes the retiring control word on the writeback edge
    ctl = ctl_word(16'd60, 1'b1, 1'b0, 1'b0, 1'b1);
    host_write(5'd24, ctl);
    wait_start(seen);
    chk("R10 desc3 started", tx_ptr, 32'h0000_7000);
    finish(3, 9'h133, ctl, 1'b1, 1'b1, 5'd24, 32'hDEAD_BEEF);

    // R7: last slot without wrap returns to descriptor 0
    arm(0, 32'h0000_8000, ctl_word(16'd50, 1'b0, 1'b0, 1'b0, 1'b0));
    wait_start(seen);
    chk("R7 back to slot 0", tx_ptr, 32'h0000_8000);
    finish(0, 9'h000, ctl_word(16'd50, 1'b0, 1'b0, 1'b0, 1'b0), 1'b0, 1'b0, '0, '0);

    summary();
    $finish;
  end

endmodule